// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers fifteen interrupt lines (numbered 1 to 15) for one processor. It presents the most urgent unmasked request as a 4-bit interrupt number with a valid flag. Each line is first synchronised. Only its rising edge counts, so a line held high raises its request once. The request is stored either in a shared pending vector or, when the line is marked for broadcast, in the force vector of every processor slot. A word-wide register interface with an 8-bit address lets software program several things: a per-line priority level (high or low), per-slot masks, per-slot force vectors, a pending clear, the broadcast selection and per-slot 4-bit extended fields. Only slot 0's mask and force feed the output.

The output stage is a small state machine whose state names the priority set being presented. SEL_IDLE means nothing is presented. SEL_LVL0 means a low-level request is presented. SEL_LVL1 means a high-level request is presented. On every clock the machine moves from any state to SEL_LVL1 if an effective high-level request exists. Otherwise it moves to SEL_LVL0 if an effective low-level request exists. Otherwise it moves to SEL_IDLE. The processor retires an interrupt by returning an acknowledge with its number.

Top module: `intc_two_level`

## Requirements
- R1: After reset every register reads 0 and `irq_valid` is 0.
- R2: Bit 0 is never stored. Writes to mask (0x40+4n), force, clear and broadcast keep bits 15:1. A write to level (0x00) keeps bits 16:1. A write to extended (0xC0+4n) keeps bits 3:0.
- R3: A rising edge on input line i sets pending bit i (read at 0x04) by the third clock edge after the change. A line that stays high sets the bit only once.
- R4: When broadcast bit i (0x14) is 1, a rising edge on line i sets bit i in the force register of every slot, and pending bit i is left unchanged.
- R5: A write to slot force register 0x80+4n makes it (old | wdata[15:1]) & ~wdata[31:17]. A clear bit wins over a set bit in the same write.
- R6: A write to 0x08 replaces slot 0's force register with wdata[15:1]. Reads of 0x08 return slot 0's force register.
- R7: Writing 1s to 0x0C clears the matching pending bits. 0x0C and 0x10 always read 0. Writes to 0x04 leave pending unchanged.
- R8: The effective vector is (pending | force0) & mask0. If any effective bit has its level bit set, the highest-numbered such bit is presented. Otherwise the highest-numbered effective bit is presented. The output shows the register state of the previous cycle, one clock behind.
- R9: An acknowledge of number k clears bit k of pending and of slot 0's force register.
- R10: Undecoded addresses read 0 and ignore writes. These include 0x18 to 0x3C and any address with bits 1:0 not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 15 | Interrupt lines 15:1, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | 4 | Number being acknowledged |
| irq_valid | output | 1 | An interrupt is presented |
| irq_num | output | 4 | Presented interrupt number |

## Verification
A wrong pending, force or mask bit shows on `irq_num` one clock after the register changes, because the bench's reference model predicts the presented number on every cycle. A broken edge detector shows as a pending bit that comes back after an acknowledge while its line is still high. Wrong write masking or a wrong set and clear order shows immediately on a read of the affected address. A priority inversion between the two levels shows as the wrong number in the cycle after the level register is written.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        SEL_IDLE = 2'd0,
        SEL_LVL0 = 2'd1,
        SEL_LVL1 = 2'd2
    } sel_state_e;

    localparam logic [5:0] WORD_LEVEL = 6'd0;
    localparam logic [5:0] WORD_PEND  = 6'd1;
    localparam logic [5:0] WORD_ALIAS = 6'd2;
    localparam logic [5:0] WORD_CLEAR = 6'd3;
    localparam logic [5:0] WORD_BCAST = 6'd5;

    localparam logic [1:0] REGION_GLOBAL = 2'b00;
    localparam logic [1:0] REGION_MASK   = 2'b01;
    localparam logic [1:0] REGION_FORCE  = 2'b10;
    localparam logic [1:0] REGION_EXT    = 2'b11;
endpackage

// File: rtl/intc_edge_sync.sv
module intc_edge_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:1] lines_i,
    output logic [W-1:0] ev_o
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    assign s1_q[0] = 1'b0;
    assign s2_q[0] = 1'b0;
    assign s3_q[0] = 1'b0;
    assign ev_o[0] = 1'b0;

    for (genvar i = 1; i < W; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q[i] <= 1'b0;
                s2_q[i] <= 1'b0;
                s3_q[i] <= 1'b0;
            end else begin
                s1_q[i] <= lines_i[i];
                s2_q[i] <= s1_q[i];
                s3_q[i] <= s2_q[i];
            end
        end
        assign ev_o[i] = s2_q[i] & ~s3_q[i];
    end

    // a held line yields no event on two consecutive cycles
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ev_o & $past(ev_o)) == '0));
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int W       = 16,
    parameter int NUM_CPU = 16,
    parameter int NUM_W   = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [7:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    input  logic [W-1:0]     ev_i,
    input  logic             ack_i,
    input  logic [NUM_W-1:0] ack_num_i,
    output logic [W-1:0]     pend_o,
    output logic [W-1:0]     frc0_o,
    output logic [W-1:0]     mask0_o,
    output logic [W-1:0]     lvl_o
);
    localparam logic [W-1:0] KEEP = {{(W-1){1'b1}}, 1'b0};

    logic         aligned;
    logic [5:0]   word;
    logic [1:0]   region;
    logic [3:0]   slot;
    logic [W-1:0] wlo, whi;
    logic [W-1:0] pend_q, pend_d, bc_q;
    logic [W:1]   lvl_q;
    logic         wr_glob;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign word    = addr_i[7:2];
    assign region  = addr_i[7:6];
    assign slot    = addr_i[5:2];
    assign wlo     = wdata_i[W-1:0] & KEEP;
    assign whi     = wdata_i[16 +: W] & KEEP;
    assign wr_glob = wr_i && aligned;

    always_comb begin
        pend_d = pend_q;
        if (wr_glob && word == WORD_CLEAR) pend_d = pend_d & ~wlo;
        if (ack_i) pend_d[ack_num_i] = 1'b0;
        pend_d = pend_d | (ev_i & ~bc_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            bc_q   <= '0;
            lvl_q  <= '0;
        end else begin
            pend_q <= pend_d;
            if (wr_glob && word == WORD_BCAST) bc_q  <= wlo;
            if (wr_glob && word == WORD_LEVEL) lvl_q <= wdata_i[W:1];
        end
    end

    logic [W-1:0] mask_all [NUM_CPU];
    logic [W-1:0] frc_all  [NUM_CPU];
    logic [3:0]   ext_all  [NUM_CPU];
    logic [NUM_CPU-1:0] slot_hit;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [W-1:0] mask_r, frc_r, frc_d;
        logic [3:0]   ext_r;
        assign slot_hit[c] = aligned && (slot == 4'(c));

        always_comb begin
            frc_d = frc_r;
            if (wr_i && slot_hit[c] && region == REGION_FORCE)
                frc_d = (frc_d | wlo) & ~whi;
            if (c == 0) begin
                if (wr_glob && word == WORD_ALIAS) frc_d = wlo;
                if (ack_i) frc_d[ack_num_i] = 1'b0;
            end
            frc_d = frc_d | (ev_i & bc_q);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_r <= '0;
                frc_r  <= '0;
                ext_r  <= '0;
            end else begin
                frc_r <= frc_d;
                if (wr_i && slot_hit[c] && region == REGION_MASK) mask_r <= wlo;
                if (wr_i && slot_hit[c] && region == REGION_EXT)  ext_r  <= wdata_i[3:0];
            end
        end

        assign mask_all[c] = mask_r;
        assign frc_all[c]  = frc_r;
        assign ext_all[c]  = ext_r;
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            unique case (region)
                REGION_GLOBAL: begin
                    if (word == WORD_LEVEL) rdata_o = 32'({lvl_q, 1'b0});
                    if (word == WORD_PEND)  rdata_o = 32'(pend_q);
                    if (word == WORD_ALIAS) rdata_o = 32'(frc_all[0]);
                    if (word == WORD_BCAST) rdata_o = 32'(bc_q);
                end
                REGION_MASK:  for (int c = 0; c < NUM_CPU; c++) if (slot_hit[c]) rdata_o = 32'(mask_all[c]);
                REGION_FORCE: for (int c = 0; c < NUM_CPU; c++) if (slot_hit[c]) rdata_o = 32'(frc_all[c]);
                REGION_EXT:   for (int c = 0; c < NUM_CPU; c++) if (slot_hit[c]) rdata_o = 32'(ext_all[c]);
                default: rdata_o = '0;
            endcase
        end
    end

    assign pend_o  = pend_q;
    assign frc0_o  = frc_all[0];
    assign mask0_o = mask_all[0];
    assign lvl_o   = {lvl_q[W-1:1], 1'b0};

    assert_bit0_unstored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0] && !frc_all[0][0] && !mask_all[0][0] && !bc_q[0]);

    assert_pend_only_from_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(ev_i & ~bc_q)) == '0));

    assert_pend_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 8'h04 && ev_i == '0 && !ack_i) |=> $stable(pend_q));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !ev_i[ack_num_i]) |=> !pend_q[$past(ack_num_i)]);
endmodule

// File: rtl/intc_select.sv
module intc_select
    import intc_pkg::*;
#(
    parameter int W     = 16,
    parameter int NUM_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     pend_i,
    input  logic [W-1:0]     frc_i,
    input  logic [W-1:0]     mask_i,
    input  logic [W-1:0]     lvl_i,
    output logic             irq_valid_o,
    output logic [NUM_W-1:0] irq_num_o
);
    sel_state_e       state_q, state_d;
    logic [W-1:0]     eff, hi_set, lo_set, pick;
    logic [NUM_W-1:0] num_d, num_q;

    assign eff    = (pend_i | frc_i) & mask_i;
    assign hi_set = eff & lvl_i;
    assign lo_set = eff & ~lvl_i;
    assign pick   = (hi_set != '0) ? hi_set : lo_set;

    always_comb begin
        num_d = '0;
        for (int i = 1; i < W; i++) if (pick[i]) num_d = NUM_W'(i);
        if (hi_set != '0)      state_d = SEL_LVL1;
        else if (lo_set != '0) state_d = SEL_LVL0;
        else                   state_d = SEL_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) num_q <= '0;
        else        num_q <= num_d;
    end

    always_comb begin
        unique case (state_q)
            SEL_IDLE: irq_valid_o = 1'b0;
            SEL_LVL0: irq_valid_o = 1'b1;
            SEL_LVL1: irq_valid_o = 1'b1;
            default:  irq_valid_o = 1'b0;
        endcase
    end
    assign irq_num_o = num_q;

    assert_valid_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (irq_num_o != '0));
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level #(
    parameter int W       = 16,
    parameter int NUM_CPU = 16,
    parameter int NUM_W   = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:1]     irq_in,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             ack_valid,
    input  logic [NUM_W-1:0] ack_num,
    output logic             irq_valid,
    output logic [NUM_W-1:0] irq_num
);
    logic [W-1:0] ev, pend, frc0, mask0, lvl;

    intc_edge_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .lines_i(irq_in), .ev_o(ev)
    );

    intc_regfile #(.W(W), .NUM_CPU(NUM_CPU), .NUM_W(NUM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .ev_i(ev),
        .ack_i(ack_valid), .ack_num_i(ack_num), .pend_o(pend),
        .frc0_o(frc0), .mask0_o(mask0), .lvl_o(lvl)
    );

    intc_select #(.W(W), .NUM_W(NUM_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .frc_i(frc0),
        .mask_i(mask0), .lvl_i(lvl), .irq_valid_o(irq_valid),
        .irq_num_o(irq_num)
    );
endmodule

// File: tb/intc_two_level_tb.sv
`timescale 1ns/1ps
module intc_two_level_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:1] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_num = '0;
    logic        irq_valid;
    logic [3:0]  irq_num;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    intc_two_level u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_valid(ack_valid), .ack_num(ack_num), .irq_valid(irq_valid),
        .irq_num(irq_num)
    );

    // behavioural reference model
    logic [15:0] m_pend, m_bc, m_lvl;
    logic [15:0] m_mask [16];
    logic [15:0] m_frc  [16];
    logic [15:0] m_s1, m_s2, m_s3;
    logic        m_valid;
    logic [3:0]  m_num;

    always @(posedge clk) begin
        logic [15:0] ev, eff, hi, lo, pk;
        if (!rst_n) begin
            m_pend = 0; m_bc = 0; m_lvl = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_valid = 0; m_num = 0;
            for (int c = 0; c < 16; c++) begin m_mask[c] = 0; m_frc[c] = 0; end
        end else begin
            ev  = m_s2 & ~m_s3;
            eff = (m_pend | m_frc[0]) & m_mask[0];
            hi  = eff & m_lvl;
            lo  = eff & ~m_lvl;
            pk  = (hi != 0) ? hi : lo;
            m_valid = (pk != 0);
            m_num = 0;
            for (int i = 1; i < 16; i++) if (pk[i]) m_num = 4'(i);
            if (bus_wr && bus_addr[1:0] == 0) begin
                if (bus_addr == 8'h00) m_lvl = bus_wdata[15:0] & 16'hFFFE;
                if (bus_addr == 8'h08) m_frc[0] = bus_wdata[15:0] & 16'hFFFE;
                if (bus_addr == 8'h0C) m_pend = m_pend & ~(bus_wdata[15:0] & 16'hFFFE);
                if (bus_addr == 8'h14) m_bc = bus_wdata[15:0] & 16'hFFFE;
                if (bus_addr >= 8'h40 && bus_addr < 8'h80)
                    m_mask[bus_addr[5:2]] = bus_wdata[15:0] & 16'hFFFE;
                if (bus_addr >= 8'h80 && bus_addr < 8'hC0)
                    m_frc[bus_addr[5:2]] = (m_frc[bus_addr[5:2]] | (bus_wdata[15:0] & 16'hFFFE))
                                           & ~(bus_wdata[31:16] & 16'hFFFE);
            end
            if (ack_valid) begin
                m_pend[ack_num] = 1'b0;
                m_frc[0][ack_num] = 1'b0;
            end
            m_pend = m_pend | (ev & ~m_bc);
            for (int c = 0; c < 16; c++) m_frc[c] = m_frc[c] | (ev & m_bc);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = {irq_in, 1'b0};
        end
    end

    // per-cycle comparison of the presented interrupt (R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq_valid !== m_valid || (m_valid && irq_num !== m_num)) begin
                errors++;
                $display("FAIL R8 cycle compare: valid=%0b num=%0d expected valid=%0b num=%0d",
                         irq_valid, irq_num, m_valid, m_num);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic out_chk(input logic v, input logic [3:0] n, input string tag);
        @(negedge clk);
        #2;
        checks++;
        if (irq_valid !== v || (v && irq_num !== n)) begin
            errors++;
            $display("FAIL %s output: valid=%0b num=%0d expected valid=%0b num=%0d",
                     tag, irq_valid, irq_num, v, n);
        end
    endtask

    task automatic ack(input logic [3:0] n);
        @(negedge clk);
        ack_valid = 1'b1; ack_num = n;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(8'h00, 0, "R1");
        rd_chk(8'h04, 0, "R1");
        rd_chk(8'h40, 0, "R1");
        out_chk(1'b0, 0, "R1");
        // R2 write masking
        wr(8'h40, 32'hFFFF_FFFF); rd_chk(8'h40, 32'h0000_FFFE, "R2");
        wr(8'h00, 32'hFFFF_FFFF); rd_chk(8'h00, 32'h0001_FFFE, "R2");
        wr(8'h00, 32'h0);
        wr(8'hC4, 32'h0000_00FF); rd_chk(8'hC4, 32'h0000_000F, "R2");
        // R3 edge latch, held line
        @(negedge clk); irq_in[5] = 1'b1;
        idle(5);
        rd_chk(8'h04, 32'h20, "R3");
        out_chk(1'b1, 5, "R3");
        ack(5);                               // R9 on pending
        idle(6);
        rd_chk(8'h04, 32'h0, "R3 held line");
        @(negedge clk); irq_in[5] = 1'b0;
        idle(4);
        // R8 priority: level 1 beats level 0, highest wins
        wr(8'h00, 32'h8);
        @(negedge clk); irq_in[3] = 1'b1; irq_in[9] = 1'b1;
        idle(6);
        out_chk(1'b1, 3, "R8 level1");
        wr(8'h00, 32'h0);
        idle(1);
        out_chk(1'b1, 9, "R8 highest");
        wr(8'h40, 32'h8);
        idle(1);
        out_chk(1'b1, 3, "R8 mask");
        wr(8'h40, 32'h0);
        idle(1);
        out_chk(1'b0, 0, "R8 masked off");
        // R7 clear, read-as-zero, pending read-only
        wr(8'h0C, 32'h0000_0208);
        rd_chk(8'h04, 32'h0, "R7 clear");
        rd_chk(8'h0C, 32'h0, "R7");
        rd_chk(8'h10, 32'h0, "R7");
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, 32'h0, "R7 pending ro");
        @(negedge clk); irq_in[3] = 1'b0; irq_in[9] = 1'b0;
        wr(8'h40, 32'hFFFE);
        // R5 force set/clear
        wr(8'h84, 32'h0000_0006); rd_chk(8'h84, 32'h6, "R5");
        wr(8'h84, 32'h0004_0010); rd_chk(8'h84, 32'h12, "R5");
        wr(8'h84, 32'h0002_0002); rd_chk(8'h84, 32'h10, "R5 clear wins");
        wr(8'h80, 32'h0000_4000);
        idle(1);
        out_chk(1'b1, 14, "R8 force");
        // R6 alias replace
        wr(8'h08, 32'h0000_0101);
        rd_chk(8'h80, 32'h100, "R6");
        rd_chk(8'h08, 32'h100, "R6");
        out_chk(1'b1, 8, "R6");
        // R9 ack clears force0
        ack(8);
        rd_chk(8'h80, 32'h0, "R9");
        idle(1);
        out_chk(1'b0, 0, "R9");
        // R4 broadcast
        wr(8'h14, 32'h0000_0081); rd_chk(8'h14, 32'h80, "R4");
        @(negedge clk); irq_in[7] = 1'b1;
        idle(6);
        rd_chk(8'h04, 32'h0, "R4 pending untouched");
        rd_chk(8'h80, 32'h80, "R4");
        rd_chk(8'h84, 32'h90, "R4");
        rd_chk(8'hBC, 32'h80, "R4");
        out_chk(1'b1, 7, "R4");
        // R10 undecoded
        wr(8'h20, 32'hFFFF_FFFF);
        rd_chk(8'h20, 32'h0, "R10");
        rd_chk(8'h3C, 32'h0, "R10");
        wr(8'h41, 32'h0);
        rd_chk(8'h41, 32'h0, "R10 unaligned");
        rd_chk(8'h40, 32'hFFFE, "R10 unaligned write ignored");
        idle(3);
        done = 1;
        summary();
    end
endmodule